// File: doc/BRIEF.md
# Indirect Entry Table Register Port

This block puts an on-chip table of 68-bit entries behind a small 32-bit register bus. The entries are never reached directly. Software stages an entry in three data words and moves it through one index register. Writing an index with the commit bit clear loads that entry into the data words. Writing an index with the commit bit set stores the data words into that entry. The data words are ordered with the most significant one first. The word at 0x34 holds entry bits 67:64. The word at 0x38 holds bits 63:32, and the word at 0x3C holds bits 31:0.

A global control register carries an enable bit, which is driven out to the rest of the switch. It also carries a self-clearing clear bit. The clear bit starts a sweep that writes zero to every entry, one entry per clock. Bits 61:60 of an entry are its type field, and a type of 0 marks the entry free, so after the sweep every entry is free. A read-only register reports a revision number.

The table itself is a single-write, single-read synchronous memory, so a block RAM can hold it.

Top module: `entry_table_port`

## Requirements
- R1: After reset the control word, the index register and all three data words read 0, and `tbl_enable` is 0.
- R2: Address 0x00 reads `{16'h0, REV_MAJOR, REV_MINOR}`. Writes to it have no effect.
- R3: A read strobe in one cycle gives `bus_rvalid` and the data in the next cycle. Unmapped addresses read 0, and `bus_rdata` is 0 in any cycle without a read result.
- R4: Words 0x38 and 0x3C store all 32 bits. Word 0x34 keeps only bits 3:0 and reads 0 in bits 31:4.
- R5: A write to 0x20 with bit 31 set and an index (bits 30:0) below DEPTH stores `{w34[3:0], w38, w3C}` into that entry. This holds at index 0 and at DEPTH-1.
- R6: A write to 0x20 with bit 31 clear and an in-range index copies the entry into the three words. The new values can be read from the second cycle after the write. A data-word write that lands in the cycle right after the load is lost.
- R7: A load or commit whose index is DEPTH or above is ignored. The data words and the index register keep their contents.
- R8: Bit 31 of 0x08 is a read/write enable bit that drives `tbl_enable`.
- R9: Writing 1 to bit 30 of 0x08 zeroes every entry, so every entry type (bits 61:60) becomes free. This takes DEPTH cycles. Bit 30 reads 1 during the sweep and 0 after it.
- R10: While a sweep runs, loads, commits and further clear requests are ignored. The sweep is not restarted.
- R11: Address 0x20 reads back the index of the last accepted load or commit in bits 30:0, with bit 31 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| tbl_enable | output | 1 | Global enable bit |

## Verification
The assertions assume that the bus never raises a read and a write in the same cycle. They also assume that software waits for a load's capture cycle before it commits, because the capture overwrites the staging words. The stimulus drives every access as a one-cycle strobe followed by an idle cycle, so both conditions hold. The deliberate data-word write in a capture cycle is the one exception. The table holds unknown contents until the first sweep, so the stimulus begins with a clear. Only after that does it load any entry that was not committed first.

// File: rtl/tbl_if_pkg.sv
package tbl_if_pkg;
  localparam int ENTRY_W = 68;
  localparam int WORD_W  = 32;
  localparam int HI_W    = ENTRY_W - 2 * WORD_W;

  localparam logic [7:0] OFS_ID    = 8'h00;
  localparam logic [7:0] OFS_CTRL  = 8'h08;
  localparam logic [7:0] OFS_TCTL  = 8'h20;
  localparam logic [7:0] OFS_W_HI  = 8'h34;
  localparam logic [7:0] OFS_W_MID = 8'h38;
  localparam logic [7:0] OFS_W_LO  = 8'h3C;

  localparam int CMT_BIT = 31;
  localparam int EN_BIT  = 31;
  localparam int CLR_BIT = 30;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ID, SEL_CTRL, SEL_TCTL, SEL_HI, SEL_MID, SEL_LO
  } rsel_e;

  typedef struct packed {
    logic ctrl;
    logic tctl;
    logic hi;
    logic mid;
    logic lo;
  } wstb_t;
endpackage

// File: rtl/tbl_reg_decode.sv
module tbl_reg_decode
  import tbl_if_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output wstb_t             wstb,
  output rsel_e             rsel
);
  always_comb begin
    rsel = SEL_NONE;
    case (addr)
      ADDR_W'(OFS_ID):    rsel = SEL_ID;
      ADDR_W'(OFS_CTRL):  rsel = SEL_CTRL;
      ADDR_W'(OFS_TCTL):  rsel = SEL_TCTL;
      ADDR_W'(OFS_W_HI):  rsel = SEL_HI;
      ADDR_W'(OFS_W_MID): rsel = SEL_MID;
      ADDR_W'(OFS_W_LO):  rsel = SEL_LO;
      default:            rsel = SEL_NONE;
    endcase
  end

  // the identification register takes no write strobe
  always_comb begin
    wstb.ctrl = wr_en && (rsel == SEL_CTRL);
    wstb.tctl = wr_en && (rsel == SEL_TCTL);
    wstb.hi   = wr_en && (rsel == SEL_HI);
    wstb.mid  = wr_en && (rsel == SEL_MID);
    wstb.lo   = wr_en && (rsel == SEL_LO);
  end
endmodule

// File: rtl/tbl_clear_seq.sv
module tbl_clear_seq #(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ptr  <= '0;
    end else if (busy) begin
      if (ptr == LAST) busy <= 1'b0;
      else             ptr  <= ptr + 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      ptr  <= '0;
    end
  end

  AST_CLR_START: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && ptr == '0)); // R9
  AST_CLR_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (ptr == $past(ptr) + 1'b1)); // R9
  AST_CLR_ENDS_AT_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(ptr) == LAST)); // R9
  AST_CLR_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy && ptr != LAST) |=> busy); // R10
endmodule

// File: rtl/tbl_entry_ram.sv
module tbl_entry_ram #(
  parameter int W     = 68,
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/entry_table_port.sv
module entry_table_port
  import tbl_if_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         DEPTH     = 64,
  parameter logic [7:0] REV_MAJOR = 8'h02,
  parameter logic [7:0] REV_MINOR = 8'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              tbl_enable
);
  localparam int IDX_W = $clog2(DEPTH);

  wstb_t wstb;
  rsel_e rsel;

  logic [HI_W-1:0]    word_hi;
  logic [WORD_W-1:0]  word_mid, word_lo;
  logic [IDX_W-1:0]   tctl_idx;
  logic               ctrl_en;
  logic               ld_pend;

  logic               clr_busy;
  logic [IDX_W-1:0]   clr_ptr;

  logic               idx_ok, acc_ok, do_load, do_commit;
  logic [IDX_W-1:0]   req_idx;

  logic               ram_we;
  logic [IDX_W-1:0]   ram_waddr;
  logic [ENTRY_W-1:0] ram_wdata, ram_rdata;
  logic [31:0]        rd_mux;

  tbl_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .wr_en(bus_wr),
    .wstb (wstb),
    .rsel (rsel)
  );

  // index in bits 30:0, compared at full width so huge values are rejected
  assign idx_ok    = ({1'b0, bus_wdata[30:0]} < 32'(DEPTH));
  assign req_idx   = bus_wdata[IDX_W-1:0];
  assign acc_ok    = wstb.tctl && idx_ok && !clr_busy;
  assign do_commit = acc_ok && bus_wdata[CMT_BIT];
  assign do_load   = acc_ok && !bus_wdata[CMT_BIT];

  tbl_clear_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_clr (
    .clk  (clk),
    .rst  (rst),
    .start(wstb.ctrl && bus_wdata[CLR_BIT]),
    .busy (clr_busy),
    .ptr  (clr_ptr)
  );

  // one write port shared by the sweep and the commit path
  always_comb begin
    ram_we    = clr_busy || do_commit;
    ram_waddr = clr_busy ? clr_ptr : req_idx;
    ram_wdata = clr_busy ? '0 : {word_hi, word_mid, word_lo};
  end

  tbl_entry_ram #(.W(ENTRY_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .re   (do_load),
    .raddr(req_idx),
    .rdata(ram_rdata)
  );

  // staging words: the load capture takes priority over bus writes
  always_ff @(posedge clk) begin
    if (rst) begin
      word_hi  <= '0;
      word_mid <= '0;
      word_lo  <= '0;
      ld_pend  <= 1'b0;
    end else begin
      ld_pend <= do_load;
      if (ld_pend) begin
        word_hi  <= ram_rdata[ENTRY_W-1:2*WORD_W];
        word_mid <= ram_rdata[2*WORD_W-1:WORD_W];
        word_lo  <= ram_rdata[WORD_W-1:0];
      end else begin
        if (wstb.hi)  word_hi  <= bus_wdata[HI_W-1:0];
        if (wstb.mid) word_mid <= bus_wdata;
        if (wstb.lo)  word_lo  <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tctl_idx <= '0;
      ctrl_en  <= 1'b0;
    end else begin
      if (acc_ok)    tctl_idx <= req_idx;
      if (wstb.ctrl) ctrl_en  <= bus_wdata[EN_BIT];
    end
  end

  assign tbl_enable = ctrl_en;

  always_comb begin
    case (rsel)
      SEL_ID:   rd_mux = {16'h0, REV_MAJOR, REV_MINOR};
      SEL_CTRL: rd_mux = {ctrl_en, clr_busy, 30'h0};
      SEL_TCTL: rd_mux = 32'(tctl_idx);
      SEL_HI:   rd_mux = 32'(word_hi);
      SEL_MID:  rd_mux = word_mid;
      SEL_LO:   rd_mux = word_lo;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_mux : '0;
    end
  end

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_rvalid |-> (bus_rdata == '0)); // R3
  AST_ID_VALUE: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(rsel == SEL_ID)) |-> (bus_rdata == {16'h0, REV_MAJOR, REV_MINOR})); // R2
  AST_BUSY_READBACK: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(rsel == SEL_CTRL)) |-> (bus_rdata[CLR_BIT] == $past(clr_busy))); // R9
  AST_OOR_WORDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wstb.tctl && !idx_ok && !ld_pend) |=> ({word_hi, word_mid, word_lo} == $past({word_hi, word_mid, word_lo}))); // R7
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    ld_pend |=> ({word_hi, word_mid, word_lo} == $past(ram_rdata))); // R6
  AST_NO_ACCESS_IN_SWEEP: assert property (@(posedge clk) disable iff (rst)
    (clr_busy && wstb.tctl) |=> (!ld_pend && tctl_idx == $past(tctl_idx))); // R10
endmodule

// File: tb/entry_table_port_tb.sv
module entry_table_port_tb;
  localparam int DEPTH = 64;
  localparam logic [7:0] A_ID = 8'h00, A_CTRL = 8'h08, A_TCTL = 8'h20;
  localparam logic [7:0] A_HI = 8'h34, A_MID = 8'h38, A_LO = 8'h3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, tbl_enable;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  entry_table_port u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .tbl_enable(tbl_enable)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [67:0] m_tbl [DEPTH];
  logic [67:0] m_words, m_pend_data;
  bit          m_pend, m_en, m_rvalid;
  int          m_clr_cnt, m_tidx;
  logic [31:0] m_rdata;
  string       m_tag;

  always @(posedge clk) begin
    if (rst) begin
      m_words = '0; m_pend = 0; m_en = 0; m_clr_cnt = 0; m_tidx = 0;
      m_rdata = '0; m_rvalid = 0; m_tag = "R1";
    end else begin
      bit          busy_old;
      logic [67:0] old_words;
      int          idx;
      busy_old  = (m_clr_cnt > 0);
      old_words = m_words;
      m_rvalid  = bus_rd;
      if (bus_rd) begin
        case (bus_addr)
          A_ID:   begin m_rdata = 32'h0000_0205; m_tag = "R2"; end
          A_CTRL: begin m_rdata = {m_en, busy_old, 30'h0}; m_tag = "R9"; end
          A_TCTL: begin m_rdata = m_tidx; m_tag = "R11"; end
          A_HI:   begin m_rdata = {28'h0, old_words[67:64]}; m_tag = "R4"; end
          A_MID:  begin m_rdata = old_words[63:32]; m_tag = "R6"; end
          A_LO:   begin m_rdata = old_words[31:0]; m_tag = "R6"; end
          default: begin m_rdata = '0; m_tag = "R3"; end
        endcase
      end else begin
        m_rdata = '0; m_tag = "R3";
      end
      if (m_pend) m_words = m_pend_data;
      else if (bus_wr) begin
        if (bus_addr == A_HI)  m_words[67:64] = bus_wdata[3:0];
        if (bus_addr == A_MID) m_words[63:32] = bus_wdata;
        if (bus_addr == A_LO)  m_words[31:0]  = bus_wdata;
      end
      m_pend = 0;
      if (busy_old) begin
        m_tbl[DEPTH - m_clr_cnt] = '0;
        m_clr_cnt--;
      end
      if (bus_wr && bus_addr == A_CTRL) begin
        m_en = bus_wdata[31];
        if (bus_wdata[30] && !busy_old) m_clr_cnt = DEPTH;
      end
      if (bus_wr && bus_addr == A_TCTL && !busy_old && bus_wdata[30:0] < DEPTH) begin
        idx    = int'(bus_wdata[30:0]);
        m_tidx = idx;
        if (bus_wdata[31]) m_tbl[idx] = old_words;
        else begin m_pend = 1; m_pend_data = m_tbl[idx]; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(bus_rdata, m_rdata, m_tag);
      check({31'h0, bus_rvalid}, {31'h0, m_rvalid}, "R3");
      check({31'h0, tbl_enable}, {31'h0, m_en}, "R8");
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    check(bus_rdata, exp, tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_chk(A_CTRL, 32'h0, "R1");
    rd_chk(A_TCTL, 32'h0, "R1");
    rd_chk(A_HI, 32'h0, "R1");
    rd_chk(A_MID, 32'h0, "R1");
    rd_chk(A_LO, 32'h0, "R1");
    check({31'h0, tbl_enable}, 32'h0, "R1");
    // R2 identification, write has no effect
    wr(A_ID, 32'hFFFF_FFFF);
    rd_chk(A_ID, 32'h0000_0205, "R2");
    // R3 unmapped addresses
    rd_chk(8'h10, 32'h0, "R3");
    rd_chk(8'h40, 32'h0, "R3");

    // stage pattern A and commit to entry 5 before the first sweep
    wr(A_HI, 32'h0000_0009); wr(A_MID, 32'h1111_2222); wr(A_LO, 32'h3333_4444);
    wr(A_TCTL, 32'h8000_0005);
    wr(A_HI, 32'h0000_0003); wr(A_MID, 32'h0BAD_F00D); wr(A_LO, 32'h1357_9BDF);
    // R9 start sweep with enable
    wr(A_CTRL, 32'hC000_0000);
    rd_chk(A_CTRL, 32'hC000_0000, "R9");
    check({31'h0, tbl_enable}, 32'h1, "R8");
    // R10 accesses during sweep ignored
    wr(A_TCTL, 32'h0000_0005);
    wr(A_TCTL, 32'h8000_0007);
    rd_chk(A_MID, 32'h0BAD_F00D, "R10");
    rd_chk(A_TCTL, 32'h0000_0005, "R10");
    repeat (20) @(negedge clk);
    wr(A_CTRL, 32'hC000_0000);
    repeat (40) @(negedge clk);
    rd_chk(A_CTRL, 32'h8000_0000, "R10");
    // R9 entries cleared: type field 61:60 free
    wr(A_TCTL, 32'h0000_0005);
    rd_chk(A_MID, 32'h0, "R9");
    rd_chk(A_LO, 32'h0, "R9");
    rd_chk(A_HI, 32'h0, "R9");

    // R4 word widths
    wr(A_HI, 32'hFFFF_FFFA); wr(A_MID, 32'h1234_5678); wr(A_LO, 32'h9ABC_DEF0);
    rd_chk(A_HI, 32'h0000_000A, "R4");
    rd_chk(A_MID, 32'h1234_5678, "R4");
    // R5 commit to 3, index 0 and last index
    wr(A_TCTL, 32'h8000_0003);
    rd_chk(A_TCTL, 32'h0000_0003, "R11");
    wr(A_LO, 32'h0000_00AA);
    wr(A_TCTL, 32'h8000_0000);
    wr(A_LO, 32'h0000_00BB);
    wr(A_TCTL, 32'h8000_0000 | (DEPTH - 1));
    wr(A_HI, 32'h0); wr(A_MID, 32'h0); wr(A_LO, 32'h0);
    // R6 load back
    wr(A_TCTL, 32'h0000_0003);
    rd_chk(A_HI, 32'h0000_000A, "R6");
    rd_chk(A_MID, 32'h1234_5678, "R6");
    rd_chk(A_LO, 32'h9ABC_DEF0, "R6");
    wr(A_TCTL, 32'h0000_0000);
    rd_chk(A_LO, 32'h0000_00AA, "R5");
    wr(A_TCTL, DEPTH - 1);
    rd_chk(A_LO, 32'h0000_00BB, "R5");
    rd_chk(A_TCTL, DEPTH - 1, "R11");
    // R6 a data write in the capture cycle is lost
    @(negedge clk); bus_wr = 1'b1; bus_addr = A_TCTL; bus_wdata = 32'h0000_0003;
    @(negedge clk); bus_addr = A_MID; bus_wdata = 32'hDEAD_BEEF;
    @(negedge clk); bus_wr = 1'b0;
    @(negedge clk);
    rd_chk(A_MID, 32'h1234_5678, "R6");
    // R7 out-of-range index
    wr(A_TCTL, DEPTH);
    wr(A_TCTL, 32'h7FFF_FFFF);
    wr(A_TCTL, 32'h8000_0000 | DEPTH);
    rd_chk(A_MID, 32'h1234_5678, "R7");
    rd_chk(A_TCTL, 32'h0000_0003, "R7");
    // R8 enable off
    wr(A_CTRL, 32'h0);
    check({31'h0, tbl_enable}, 32'h0, "R8");
    rd_chk(A_CTRL, 32'h0, "R8");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule